// File: doc/BRIEF.md
# Three-Phase Carrier PWM Timer

This block produces the raw positive-phase drive pulses for a three-phase motor bridge from one shared carrier timer. A 16-bit carrier counter sets the modulation period. In sawtooth mode it counts once through 0..m. In triangular mode it runs the same range twice, as a rising half and then a falling half, so the period doubles. Each time the carrier wraps, a carrier start event restarts three one-shot width timers, one per phase. Each timer holds its phase output active for a programmed number of count ticks.

Width, period, mode and force settings are sampled only at a carrier start. Writes made in the middle of a period therefore never disturb the pulse in flight. A carrier interrupt is raised on start events and can be thinned so that it fires once every k carriers. The count tick comes from a small prescaler. The prescaler either passes the base enable through, divides it by 2, 8 or 32, or divides a slow auxiliary enable by 32. Dead time, complementary outputs and output protection belong to a later stage.

Top module: `tri_carrier_pwm`

## Requirements
- R1: After reset, `phase_out` is 000 and `carrier_irq` is 0.
- R2: With `tri_mode`=0, the carrier period is (m+1) count ticks, where m is `period` and ranges over 0..65535.
- R3: With `tri_mode`=1, the carrier period is 2×(m+1) count ticks.
- R4: With `tri_mode`=0, phase i goes high at each carrier start and stays high for n ticks, where n is `width_a[16*i +: 16]`. `dual_width` has no effect in this mode.
- R5: With `tri_mode`=1 and `dual_width`=0, the phase pulse lasts 2×n ticks.
- R6: With `tri_mode`=1 and `dual_width`=1, the pulse lasts a+b ticks. Here a is the first-half width from `width_a` and b is the second-half width from `width_b[16*i +: 16]`.
- R7: A width, period or mode value changed in the middle of a carrier takes effect only from the next carrier start. The pulse in flight keeps its old length.
- R8: A width of 0 gives no pulse; the phase stays low for the whole carrier.
- R9: If `force_en[i]` is 1 at a carrier start, phase i holds `force_lvl[i]` constant for that whole carrier.
- R10: `carrier_irq` is a one-clock pulse that fires on every k-th carrier start, where k is `irq_every` (1..15) and the value 0 acts as 1. The pulse is high in the same clock in which the new phase pulses begin.
- R11: `src_sel` picks the count tick: 0 = every `base_en`, 1 = every 2nd `base_en`, 2 = every 8th `base_en`, 3 = every 32nd `base_en`, 4 = every 32nd `aux_en`. Codes 5..7 give no tick, which freezes the carrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_en | input | 1 | Base count enable (undivided source) |
| aux_en | input | 1 | Slow auxiliary clock enable |
| src_sel | input | 3 | Count source select |
| tri_mode | input | 1 | 1 = triangular carrier, 0 = sawtooth |
| dual_width | input | 1 | 1 = separate widths for the two triangular halves |
| period | input | 16 | Carrier setting m |
| width_a | input | 48 | Per-phase width n (first-half width in dual mode), 16 bits per phase |
| width_b | input | 48 | Per-phase second-half width, 16 bits per phase |
| force_en | input | 3 | Per-phase force enable |
| force_lvl | input | 3 | Per-phase forced level |
| irq_every | input | 4 | Interrupt thinning factor k |
| phase_out | output | 3 | Raw phase outputs U, V, W in bits 0, 1, 2 |
| carrier_irq | output | 1 | Carrier interrupt pulse |

## Verification
The bench measures the interrupt spacing and the high-run lengths directly in clocks. A carrier that is off by one in the wrap compare would show up there as an (m+2)-tick or m-tick period, and a triangular mode that forgets its second half would show a single-length period. The mid-carrier width write is aimed at the deferral rule: a design that loads the live width would cut or stretch the pulse already running instead of changing only the next one. Width zero, forcing, the interrupt thinning factor zero and the dead source codes are each probed separately. A design that got any of these wrong would emit a stray pulse, leak the counter output through a forced phase, fire the interrupt every carrier regardless of k, or keep counting on an unused source.

// File: rtl/cpw_pkg.sv
// Shared constants for the three-phase carrier PWM timer.
package cpw_pkg;
    typedef enum logic [2:0] {
        SRC_DIV1  = 3'd0,
        SRC_DIV2  = 3'd1,
        SRC_DIV8  = 3'd2,
        SRC_DIV32 = 3'd3,
        SRC_AUX32 = 3'd4
    } cpw_src_e;
endpackage

// File: rtl/cpw_tick_sel.sv
// Count tick prescaler. Derives the carrier count tick from a base enable
// (undivided or divided by 2, 8, 32) or from an auxiliary enable divided by 32.
// Assumes the enables are single-clock strobes synchronous to clk.
module cpw_tick_sel #(
    parameter int PRE_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_en,
    input  logic       aux_en,
    input  logic [2:0] src_sel,
    output logic       tick
);
    import cpw_pkg::*;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] aux_q;

    // Free-running divider of the base enable.
    always_ff @(posedge clk) begin
        if (!rst_n)       pre_q <= '0;
        else if (base_en) pre_q <= pre_q + 1'b1;
    end

    // Free-running divider of the auxiliary enable.
    always_ff @(posedge clk) begin
        if (!rst_n)      aux_q <= '0;
        else if (aux_en) aux_q <= aux_q + 1'b1;
    end

    // Pick the tick according to the source code; unused codes never tick.
    always_comb begin
        case (src_sel)
            SRC_DIV1:  tick = base_en;
            SRC_DIV2:  tick = base_en && pre_q[0];
            SRC_DIV8:  tick = base_en && (&pre_q[2:0]);
            SRC_DIV32: tick = base_en && (&pre_q);
            SRC_AUX32: tick = aux_en && (&aux_q);
            default:   tick = 1'b0;
        endcase
    end

    assert_tick_base_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && src_sel <= 3'd3) |-> base_en);
    assert_tick_aux_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && src_sel == 3'd4) |-> aux_en);
endmodule

// File: rtl/cpw_carrier.sv
// Carrier counter. Sawtooth counts 0..m once per carrier; triangular counts
// 0..m for the rising half and again for the falling half. Period and mode
// are sampled at each carrier start, so mid-carrier writes wait a boundary.
module cpw_carrier #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] period,
    input  logic          tri_mode,
    output logic          start
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] m_q;
    logic          tri_q;
    logic          half_q;
    logic          at_top;

    assign at_top = (cnt_q == m_q);
    assign start  = tick && at_top && (!tri_q || half_q);

    // Advance the count, switch halves, and reload the shadows at a start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            m_q    <= '0;
            tri_q  <= 1'b0;
            half_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
            m_q    <= period;
            tri_q  <= tri_mode;
        end else if (tick) begin
            if (at_top) begin
                cnt_q  <= '0;
                half_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= m_q);
    assert_half_tri_R3: assert property (@(posedge clk) disable iff (!rst_n)
        half_q |-> tri_q);
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
endmodule

// File: rtl/cpw_phase_shot.sv
// One phase: a one-shot width timer reloaded at every carrier start. The
// load value is n (sawtooth), 2n (triangular) or a+b (triangular, dual).
// The force bits are sampled at the start and hold for the whole carrier.
module cpw_phase_shot #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic          tri_mode,
    input  logic          dual_width,
    input  logic [CW-1:0] wid_a,
    input  logic [CW-1:0] wid_b,
    input  logic          frc_en,
    input  logic          frc_lvl,
    output logic          ph
);
    logic [CW:0] rem_q;
    logic [CW:0] load_w;
    logic        frc_en_q;
    logic        frc_lvl_q;

    // Pulse length for the carrier that is starting.
    always_comb begin
        if (!tri_mode)       load_w = {1'b0, wid_a};
        else if (dual_width) load_w = {1'b0, wid_a} + {1'b0, wid_b};
        else                 load_w = {wid_a, 1'b0};
    end

    // Reload at a start, otherwise count the active pulse down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q     <= '0;
            frc_en_q  <= 1'b0;
            frc_lvl_q <= 1'b0;
        end else if (start) begin
            rem_q     <= load_w;
            frc_en_q  <= frc_en;
            frc_lvl_q <= frc_lvl;
        end else if (tick && rem_q != '0) begin
            rem_q     <= rem_q - 1'b1;
        end
    end

    assign ph = frc_en_q ? frc_lvl_q : (rem_q != '0);

    assert_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !start && rem_q != '0) |=> (rem_q == $past(rem_q) - 1'b1));
    assert_defer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !tick) |=> $stable(rem_q));
    assert_force_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(frc_en_q) && $stable(frc_lvl_q)));
endmodule

// File: rtl/cpw_irq_thin.sv
// Carrier interrupt thinning: fires on every k-th carrier start (k = 0 acts
// as 1). Lowering k mid-run fires at the next start rather than wrapping.
module cpw_irq_thin #(
    parameter int KW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [KW-1:0] k_sel,
    output logic          irq
);
    logic [KW-1:0] dcnt_q;
    logic [KW-1:0] k_eff;
    logic          hit;

    assign k_eff = (k_sel == '0) ? KW'(1) : k_sel;
    assign hit   = (dcnt_q >= k_eff - 1'b1);

    // Count starts and emit one-clock interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt_q <= '0;
            irq    <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (start) begin
                if (hit) begin
                    dcnt_q <= '0;
                    irq    <= 1'b1;
                end else begin
                    dcnt_q <= dcnt_q + 1'b1;
                end
            end
        end
    end

    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (dcnt_q == '0));
    assert_dcnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dcnt_q != {KW{1'b1}});
    assert_irq_needs_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !irq);
endmodule

// File: rtl/tri_carrier_pwm.sv
// Top: prescaler, shared carrier, one one-shot per phase, interrupt thinning.
// Assumes register inputs are held stable by the surrounding logic; they are
// sampled only at carrier starts.
module tri_carrier_pwm #(
    parameter int CW  = 16,
    parameter int NPH = 3,
    parameter int KW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_en,
    input  logic              aux_en,
    input  logic [2:0]        src_sel,
    input  logic              tri_mode,
    input  logic              dual_width,
    input  logic [CW-1:0]     period,
    input  logic [NPH*CW-1:0] width_a,
    input  logic [NPH*CW-1:0] width_b,
    input  logic [NPH-1:0]    force_en,
    input  logic [NPH-1:0]    force_lvl,
    input  logic [KW-1:0]     irq_every,
    output logic [NPH-1:0]    phase_out,
    output logic              carrier_irq
);
    localparam int PRE_W = 5;

    logic tick;
    logic start;

    cpw_tick_sel #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .base_en(base_en), .aux_en(aux_en),
        .src_sel(src_sel), .tick(tick)
    );

    cpw_carrier #(.CW(CW)) u_car (
        .clk(clk), .rst_n(rst_n), .tick(tick), .period(period),
        .tri_mode(tri_mode), .start(start)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        cpw_phase_shot #(.CW(CW)) u_shot (
            .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
            .tri_mode(tri_mode), .dual_width(dual_width),
            .wid_a(width_a[i*CW +: CW]), .wid_b(width_b[i*CW +: CW]),
            .frc_en(force_en[i]), .frc_lvl(force_lvl[i]), .ph(phase_out[i])
        );
    end

    cpw_irq_thin #(.KW(KW)) u_irq (
        .clk(clk), .rst_n(rst_n), .start(start), .k_sel(irq_every),
        .irq(carrier_irq)
    );

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (phase_out == '0 && !carrier_irq));
endmodule

// File: tb/sim_tri_carrier_pwm.sv
`timescale 1ns/1ps
module sim_tri_carrier_pwm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_en = 1'b1, aux_en = 1'b0;
    logic [2:0]  src_sel = 3'd0;
    logic        tri_mode = 1'b0, dual_width = 1'b0;
    logic [15:0] period = 16'd9;
    logic [47:0] width_a = '0, width_b = '0;
    logic [2:0]  force_en = '0, force_lvl = '0;
    logic [3:0]  irq_every = 4'd1;
    logic [2:0]  phase_out;
    logic        carrier_irq;

    int total = 0, bad = 0;
    int     exp_q[$], act_q[$];
    string  tag_q[$];
    bit     done = 0;

    always #2 clk = ~clk;

    tri_carrier_pwm u0 (
        .clk(clk), .rst_n(rst_n), .base_en(base_en), .aux_en(aux_en),
        .src_sel(src_sel), .tri_mode(tri_mode), .dual_width(dual_width),
        .period(period), .width_a(width_a), .width_b(width_b),
        .force_en(force_en), .force_lvl(force_lvl), .irq_every(irq_every),
        .phase_out(phase_out), .carrier_irq(carrier_irq)
    );

    // Driver side: push the expected value with its requirement tag.
    task automatic expect_val(input string tag, input int e);
        tag_q.push_back(tag);
        exp_q.push_back(e);
    endtask

    // Monitor side: compare each measured value against the next expectation.
    always @(negedge clk) begin
        if (act_q.size() > 0 && exp_q.size() > 0) begin
            int a, e;
            string t;
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (a != e) begin
                bad++;
                $display("FAIL %s: actual=%0d expected=%0d", t, a, e);
            end
        end
    end

    task automatic wait_irq();
        do @(negedge clk); while (!carrier_irq);
    endtask

    task automatic meas_period();
        int n = 0;
        wait_irq();
        do begin @(negedge clk); n++; end while (!carrier_irq);
        act_q.push_back(n);
    endtask

    task automatic meas_high(input int ph);
        int n = 0;
        while (phase_out[ph]) @(negedge clk);
        while (!phase_out[ph]) @(negedge clk);
        while (phase_out[ph]) begin n++; @(negedge clk); end
        act_q.push_back(n);
    endtask

    task automatic count_level(input int ph, input logic lvl, input int win);
        int n = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (phase_out[ph] == lvl) n++;
        end
        act_q.push_back(n);
    endtask

    task automatic settle();
        wait_irq();
        wait_irq();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_val("R1 phase_out after reset", 0);
        act_q.push_back(int'(phase_out));
        expect_val("R1 irq after reset", 0);
        act_q.push_back(int'(carrier_irq));

        // Sawtooth, m=9, widths 4/6/1
        width_a = {16'd1, 16'd6, 16'd4};
        settle();
        expect_val("R2 sawtooth period m=9", 10); meas_period();
        expect_val("R4 phase0 width 4", 4); meas_high(0);
        expect_val("R4 phase1 width 6", 6); meas_high(1);
        expect_val("R4 phase2 width 1", 1); meas_high(2);
        dual_width = 1'b1; width_b = {16'd7, 16'd7, 16'd7};
        settle();
        expect_val("R4 dual ignored in sawtooth", 4); meas_high(0);
        dual_width = 1'b0;

        // Triangular single and dual
        tri_mode = 1'b1; width_a = {16'd1, 16'd2, 16'd3};
        settle();
        expect_val("R3 triangular period m=9", 20); meas_period();
        expect_val("R5 triangular width 2x3", 6); meas_high(0);
        dual_width = 1'b1; width_a[15:0] = 16'd2; width_b[15:0] = 16'd5;
        settle();
        expect_val("R6 dual width 2+5", 7); meas_high(0);
        dual_width = 1'b0; tri_mode = 1'b0;

        // Deferred width write
        period = 16'd19; width_a[15:0] = 16'd4;
        settle();
        wait_irq();
        width_a[15:0] = 16'd12;
        begin
            int n = 0;
            while (phase_out[0]) begin n++; @(negedge clk); end
            expect_val("R7 pulse in flight keeps old width", 4);
            act_q.push_back(n);
        end
        expect_val("R7 next carrier uses new width", 12); meas_high(0);

        // Width zero
        period = 16'd9; width_a[47:32] = 16'd0;
        settle();
        expect_val("R8 width 0 gives no high", 0); count_level(2, 1'b1, 20);

        // Forcing
        width_a[31:16] = 16'd4; force_en = 3'b010; force_lvl = 3'b010;
        settle();
        expect_val("R9 forced high never low", 0); count_level(1, 1'b0, 20);
        force_lvl = 3'b000;
        settle();
        expect_val("R9 forced low never high", 0); count_level(1, 1'b1, 20);
        force_en = 3'b000;

        // Interrupt thinning
        period = 16'd4; irq_every = 4'd3;
        settle();
        expect_val("R10 irq every 3 carriers", 15); meas_period();
        irq_every = 4'd0;
        settle();
        expect_val("R10 k=0 acts as 1", 5); meas_period();

        // Count sources
        irq_every = 4'd1; period = 16'd3; src_sel = 3'd2;
        settle();
        expect_val("R11 divide by 8 source", 32); meas_period();
        src_sel = 3'd4; base_en = 1'b0; aux_en = 1'b1; period = 16'd1;
        settle();
        expect_val("R11 aux divide by 32 source", 64); meas_period();
        src_sel = 3'd5;
        repeat (70) @(negedge clk);
        begin
            int n = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (carrier_irq) n++;
            end
            expect_val("R11 unused source code gives no irq", 0);
            act_q.push_back(n);
        end

        repeat (5) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule